// File: doc/BRIEF.md
# Memory access wait-state calculator

This block works out how many extra bus cycles a single memory access costs. It is purely combinational. The caller presents the address of the access, whether the access is sequential or non-sequential, the access width, a flag that is high while the display is drawing the visible part of a line, and the timing configuration word. The block returns a small unsigned cycle count in the same cycle.

The top byte of the address selects the region. Three cartridge windows each take their cost from lookup tables, indexed by their own fields of the configuration word. A 32-bit cartridge access is charged as two 16-bit halves. External work RAM has a fixed cost that depends only on width. The three video memories (palette, VRAM and object attribute memory) have a fixed cost that depends on width, plus a penalty while the display draws a line. Every other region costs nothing.

Top module: `wait_calc`

## Requirements
- R1: A non-sequential 8- or 16-bit access to a cartridge window costs a value picked by that window's 2-bit first-access field: code 0 gives 4, code 1 gives 3, code 2 gives 2 and code 3 gives 8.
- R2: A non-sequential 32-bit cartridge access costs the first-access value of R1 plus one second-access value of R3.
- R3: A sequential 8- or 16-bit cartridge access costs a value picked by that window's 1-bit second-access field: 0 gives 2 and 1 gives 1.
- R4: A sequential 32-bit cartridge access costs twice the second-access value of R3.
- R5: Window 0 covers top address bytes 0x08 and 0x09 and takes its first-access field from cfg bits [3:2] and its second-access bit from cfg bit 4. Window 1 covers 0x0A and 0x0B and uses bits [6:5] and bit 7. Window 2 covers 0x0C and 0x0D and uses bits [9:8] and bit 10. No window reads any other window's bits.
- R6: An access with top byte 0x02 (external work RAM) costs 6 at 32 bits and 3 otherwise, whatever the access type and the draw flag.
- R7: An access with top byte 0x05, 0x06 or 0x07 (video memories) costs 2 at 32 bits and 1 otherwise, plus 1 while the draw flag is high.
- R8: Every other top byte, including 0x00, 0x03, 0x04, 0x0E, 0x0F and anything above 0x0F, costs 0. The draw flag and the configuration word have no effect there.
- R9: Width code 0 means 8 bits, 1 means 16 bits and 2 means 32 bits. Code 3 is charged as 16 bits. accSeq high means sequential.
- R10: The draw flag has no effect on cartridge or external work RAM costs, and the low 24 address bits have no effect on any cost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 32 | Byte address of the access |
| accSeq | input | 1 | High for a sequential access |
| accWidth | input | 2 | Width code: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit, 3 is charged as 16-bit |
| hDraw | input | 1 | High while the display draws the visible part of a line |
| waitCfg | input | 11 | Timing configuration word with per-window access fields |
| extraCycles | output | 4 | Extra bus cycles for this access |

## Verification
Two pairs of functions can meet on one access. On a video access, the width doubling and the draw penalty stack, so the sweep covers every width with the flag both high and low and expects the sum. On a sequential or non-sequential 32-bit cartridge access, two table lookups combine, so the whole configuration word is swept for every window with every access type and width. Each window must follow only its own fields while the other windows' bits change around it. Each combination is compared with a cost the bench computes arithmetically from the requirement tables.

// File: rtl/wait_pkg.sv
package wait_pkg;
  localparam int unsigned CNT_W = 4;

  localparam logic [7:0] TOP_EXT_RAM = 8'h02;
  localparam logic [7:0] TOP_VID_LO  = 8'h05;
  localparam logic [7:0] TOP_VID_HI  = 8'h07;
  localparam logic [7:0] TOP_CART_LO = 8'h08;
  localparam logic [7:0] TOP_CART_HI = 8'h0D;

  localparam logic [1:0] WIDTH_32 = 2'd2;

  typedef struct packed {
    logic       cartHit;
    logic [1:0] winSel;
    logic       extHit;
    logic       vidHit;
    logic       wide;
    logic       seqAcc;
    logic       drawPen;
  } waitStrobe_t;
endpackage

// File: rtl/wait_ctrl.sv
module wait_ctrl
  import wait_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              accSeq,
  input  logic [1:0]        accWidth,
  input  logic              hDraw,
  output waitStrobe_t       stb
);
  logic [7:0] topByte;
  assign topByte = addr[ADDR_W-1 -: 8];

  always_comb begin
    stb         = '0;
    stb.cartHit = (topByte >= TOP_CART_LO) && (topByte <= TOP_CART_HI);
    // windows are pairs of top bytes starting at 0x08
    stb.winSel  = stb.cartHit ? topByte[2:1] : 2'd0;
    stb.extHit  = (topByte == TOP_EXT_RAM);
    stb.vidHit  = (topByte >= TOP_VID_LO) && (topByte <= TOP_VID_HI);
    stb.wide    = (accWidth == WIDTH_32);
    stb.seqAcc  = accSeq;
    stb.drawPen = hDraw && stb.vidHit;
  end

  always_comb begin
    if (!$isunknown(addr)) begin
      AST_ONE_REGION: assert ($onehot0({stb.cartHit, stb.extHit, stb.vidHit})); // R8
      AST_WIN_RANGE: assert (!stb.cartHit || stb.winSel != 2'd3); // R5
    end
  end
endmodule

// File: rtl/wait_path.sv
module wait_path
  import wait_pkg::*;
#(
  parameter int unsigned NUM_WIN = 3,
  parameter int unsigned CFG_W   = 11,
  parameter int unsigned CFG_LSB = 2
) (
  input  waitStrobe_t      stb,
  input  logic [CFG_W-1:0] waitCfg,
  output logic [CNT_W-1:0] extraCycles
);
  localparam int unsigned FLD_W = 3;

  logic [1:0] firstFld [NUM_WIN];
  logic       secFld   [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int unsigned BASE = CFG_LSB + FLD_W * w;
    assign firstFld[w] = waitCfg[BASE +: 2];
    assign secFld[w]   = waitCfg[BASE + 2];
  end

  function automatic logic [CNT_W-1:0] firstCost(input logic [1:0] code);
    case (code)
      2'd0:    firstCost = CNT_W'(4);
      2'd1:    firstCost = CNT_W'(3);
      2'd2:    firstCost = CNT_W'(2);
      default: firstCost = CNT_W'(8);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] secCost(input logic code);
    secCost = code ? CNT_W'(1) : CNT_W'(2);
  endfunction

  logic [1:0]       selFirst;
  logic             selSec;
  logic [CNT_W-1:0] leadCost;
  logic [CNT_W-1:0] tailCost;
  logic [CNT_W-1:0] cartCost;
  logic [CNT_W-1:0] extCost;
  logic [CNT_W-1:0] vidCost;

  always_comb begin
    selFirst = 2'd0;
    selSec   = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (stb.winSel == w[1:0]) begin
        selFirst = firstFld[w];
        selSec   = secFld[w];
      end
    end
    leadCost = stb.seqAcc ? secCost(selSec) : firstCost(selFirst);
    tailCost = stb.wide ? secCost(selSec) : '0;
    cartCost = leadCost + tailCost;
    extCost  = stb.wide ? CNT_W'(6) : CNT_W'(3);
    vidCost  = (stb.wide ? CNT_W'(2) : CNT_W'(1)) + CNT_W'(stb.drawPen);
    if (stb.cartHit)     extraCycles = cartCost;
    else if (stb.extHit) extraCycles = extCost;
    else if (stb.vidHit) extraCycles = vidCost;
    else                 extraCycles = '0;
  end

  always_comb begin
    if (!$isunknown({stb, waitCfg})) begin
      AST_CART_BOUND: assert (!stb.cartHit || (extraCycles >= 1 && extraCycles <= 10)); // R1
      AST_SEQ_WIDE_EVEN: assert (!(stb.cartHit && stb.seqAcc && stb.wide) || !extraCycles[0]); // R4
      AST_EXT_SET: assert (!stb.extHit || extraCycles == 3 || extraCycles == 6); // R6
      AST_VID_BOUND: assert (!stb.vidHit || (extraCycles >= 1 && extraCycles <= 3)); // R7
      AST_IDLE_ZERO: assert (stb.cartHit || stb.extHit || stb.vidHit || extraCycles == 0); // R8
    end
  end
endmodule

// File: rtl/wait_calc.sv
module wait_calc
  import wait_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned NUM_WIN = 3,
  parameter int unsigned CFG_LSB = 2,
  parameter int unsigned CFG_W   = CFG_LSB + 3 * NUM_WIN
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              accSeq,
  input  logic [1:0]        accWidth,
  input  logic              hDraw,
  input  logic [CFG_W-1:0]  waitCfg,
  output logic [CNT_W-1:0]  extraCycles
);
  waitStrobe_t stb;

  wait_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr(addr), .accSeq(accSeq), .accWidth(accWidth), .hDraw(hDraw), .stb(stb)
  );

  wait_path #(.NUM_WIN(NUM_WIN), .CFG_W(CFG_W), .CFG_LSB(CFG_LSB)) u_path (
    .stb(stb), .waitCfg(waitCfg), .extraCycles(extraCycles)
  );
endmodule

// File: tb/sim_wait_calc.sv
module sim_wait_calc;
  logic        clk = 1'b0;
  logic [31:0] addr;
  logic        accSeq;
  logic [1:0]  accWidth;
  logic        hDraw;
  logic [10:0] waitCfg;
  logic [3:0]  extraCycles;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [23:0] lfsr = 24'h5A3C1F;

  always #5 clk = ~clk;

  wait_calc u0 (
    .addr(addr), .accSeq(accSeq), .accWidth(accWidth), .hDraw(hDraw),
    .waitCfg(waitCfg), .extraCycles(extraCycles)
  );

  function automatic int nVal(input int code);
    int t[4] = '{4, 3, 2, 8};
    return t[code];
  endfunction

  function automatic int sVal(input int code);
    return (code == 0) ? 2 : 1;
  endfunction

  function automatic int model(input int top, input bit sq, input int wd,
                               input bit drw, input logic [10:0] cfg);
    bit is32;
    int w, f, s;
    is32 = (wd == 2);
    if (top >= 8 && top <= 13) begin
      w = (top - 8) / 2;
      f = cfg[2 + 3*w +: 2];
      s = cfg[4 + 3*w];
      if (sq) return is32 ? 2 * sVal(s) : sVal(s);
      return is32 ? nVal(f) + sVal(s) : nVal(f);
    end
    if (top == 2) return is32 ? 6 : 3;
    if (top >= 5 && top <= 7) return (is32 ? 2 : 1) + (drw ? 1 : 0);
    return 0;
  endfunction

  function automatic string reqOf(input int top, input bit sq, input int wd);
    if (top >= 8 && top <= 13) begin
      if (wd == 3) return "R9";
      if (sq) return (wd == 2) ? "R4" : "R3";
      return (wd == 2) ? "R2" : "R1";
    end
    if (top == 2) return "R6";
    if (top >= 5 && top <= 7) return "R7";
    return "R8";
  endfunction

  task automatic probe(input int top, input bit sq, input int wd, input bit drw,
                       input logic [10:0] cfg, input string tag);
    int exp;
    lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
    addr = {top[7:0], lfsr};   // R10: arbitrary low bits
    accSeq = sq; accWidth = wd[1:0]; hDraw = drw; waitCfg = cfg;
    #1;
    exp = model(top, sq, wd, drw, cfg);
    total++;
    if (int'(extraCycles) != exp) begin
      bad++;
      if (bad < 20)
        $display("FAIL %s top=%02h seq=%0d w=%0d draw=%0d cfg=%03h got=%0d exp=%0d",
                 tag, top, sq, wd, drw, cfg, extraCycles, exp);
    end
  endtask

  initial begin
    addr = '0; accSeq = 0; accWidth = 0; hDraw = 0; waitCfg = '0;
    #2;
    // reset-like state: address 0 costs nothing (R8)
    probe(0, 0, 0, 0, 11'h000, "R8");
    // cartridge windows: full config sweep, all types and widths (R1..R5, R9, R10)
    for (int top = 8; top <= 13; top++)
      for (int cfg = 0; cfg < 2048; cfg++)
        for (int sq = 0; sq < 2; sq++)
          for (int wd = 0; wd < 4; wd++)
            probe(top, sq[0], wd, cfg[0], cfg[10:0], reqOf(top, sq[0], wd));
    // fixed-cost and empty regions, plus high top bytes (R6, R7, R8, R9, R10)
    for (int top = 0; top < 8; top++)
      for (int cfg = 0; cfg < 2048; cfg += 97)
        for (int sq = 0; sq < 2; sq++)
          for (int wd = 0; wd < 4; wd++)
            for (int drw = 0; drw < 2; drw++)
              probe(top, sq[0], wd, drw[0], cfg[10:0], reqOf(top, sq[0], wd));
    for (int top = 14; top < 256; top += 7)
      for (int wd = 0; wd < 4; wd++)
        for (int drw = 0; drw < 2; drw++)
          probe(top, 1'b0, wd, drw[0], 11'h7FF, "R8");
    // window field isolation spot checks (R5)
    probe(8,  0, 1, 0, 11'b000_000_011_00, "R5");
    probe(10, 0, 1, 0, 11'b000_011_000_00, "R5");
    probe(12, 0, 1, 0, 11'b011_000_000_00, "R5");
    probe(13, 1, 2, 1, 11'b100_000_000_00, "R5");
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired got=hang exp=finish");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule